// File: doc/BRIEF.md
# Compare-Match Interval Timer Channel

This block is one channel of an interval timer on a memory-mapped register bus. A free-running prescaler divides the bus clock into a slow counting tick, and the divide ratio is chosen by a field in the channel's control word. On each tick a started channel either advances its up-counter by one or, when the counter already equals the compare value, returns it to zero. A period therefore lasts compare + 1 ticks. A match sets a sticky flag, and the flag drives a level interrupt while the interrupt enable is set.

The start bits of all channels sit in one run register, one bit per channel. Software changes its own bit by reading the register, changing that bit and writing the whole register back. The counter belongs to the slow tick domain. A value written to it is handed over through a toggle request that must be seen on two ticks before it lands. Until then, reads return the old count. A 16-bit build (parameter `CNT_W`) moves the match flag to bit 7 and has no wrap flag.

Top module: `match_timer`

## Requirements
- R1: After reset the control word, counter, compare value and run register all read zero, and `irq` is low.
- R2: The run register holds one bit per channel, and every bit reads back as last written. Only bit `CH_IDX` lets this channel count. The run register is reached with `sel_str` = 1.
- R3: Control bits [1:0] select the tick divider: 8 for 0, 32 for 1, 128 for 2 and 512 for 3. A started channel changes its counter once per tick.
- R4: When a tick finds the counter equal to the compare value, the counter becomes 0 and the match flag (control bit 15) is set. Successive match flags are therefore (compare + 1) x divider clocks apart.
- R5: Each flag is sticky. Writing 0 to a flag bit clears it, and writing 1 to a flag bit leaves it unchanged.
- R6: If a match and a control write that clears the match flag fall in the same cycle, the flag stays set.
- R7: `irq` is high exactly while both the match flag and the interrupt enable (control bit 6) are set, and it stays high until software writes.
- R8: Writing zero to the control word clears the flags and the enable, so `irq` stays low even after later matches.
- R9: A counter write takes effect on the second tick after the write. Reads taken before that return the previous count.
- R10: Byte addresses are word offset x 4: control at 0x0, counter at 0x4, compare at 0x8. Offset 0xC reads zero.
- R11: When the counter passes from all ones to zero without a match, the wrap flag (control bit 14) is set. It is cleared like the match flag, independently of it.
- R12: While the channel's run bit is clear the counter holds its value. A counter write still completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the prescaler runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_str | input | 1 | 1 selects the shared run register, 0 selects channel registers |
| addr | input | 4 | Byte address within the channel |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is the collision of a match with a flag-clearing write in the same clock cycle. The tick phase is not visible at the ports. The bench learns it from the cycle in which a match flag first appears. It then counts exactly one period of (compare + 1) x divider clocks and lands the clearing write on the edge of the next match. The wrap flag is reached by preloading the counter just below all ones, with the compare value set above the wrap point.

// File: rtl/mt_pkg.sv
package mt_pkg;

  typedef enum logic [1:0] {
    WRD_CTRL = 2'd0,
    WRD_CNT  = 2'd1,
    WRD_CMP  = 2'd2,
    WRD_NONE = 2'd3
  } word_e;

  localparam int unsigned DIV_BASE_LOG2 = 3;
  localparam int unsigned DIV_STEP_LOG2 = 2;

  function automatic int unsigned div_log2(input logic [1:0] sel);
    return DIV_BASE_LOG2 + DIV_STEP_LOG2 * int'(sel);
  endfunction

endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  import mt_pkg::*;

  localparam int PRE_W = DIV_BASE_LOG2 + DIV_STEP_LOG2 * ((1 << SEL_W) - 1);

  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic [PRE_W:0]   one_sh;
  logic [PRE_W-1:0] lim;

  always_comb begin
    one_sh = (PRE_W+1)'(1) << div_log2(sel);
    lim    = PRE_W'(one_sh - {{PRE_W{1'b0}}, 1'b1});
    tick   = (pcnt_q >= lim);
    pcnt_d = tick ? '0 : pcnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R3: the smallest divider is 8, so ticks never come back to back
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/mt_count_core.sv
module mt_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] cmp,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wval,
  output logic [CNT_W-1:0] cnt,
  output logic             match_ev,
  output logic             wrap_ev
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] pend_q, pend_d;
  logic             req_q, req_d;
  logic             s1_q, s1_d, s2_q, s2_d;
  logic             load, pending, busy;

  always_comb begin
    pending  = (req_q != s2_q);
    load     = tick && (s1_q != s2_q);
    busy     = pending && !load;
    pend_d   = wr_cnt ? wval : pend_q;
    req_d    = (wr_cnt && !busy) ? !req_q : req_q;
    s1_d     = tick ? req_q : s1_q;
    s2_d     = tick ? s1_q : s2_q;
    cnt_d    = cnt_q;
    match_ev = 1'b0;
    wrap_ev  = 1'b0;
    if (load) begin
      cnt_d = pend_q;
    end else if (tick && run) begin
      if (cnt_q == cmp) begin
        cnt_d    = '0;
        match_ev = 1'b1;
      end else begin
        cnt_d   = cnt_q + CNT_W'(1);
        wrap_ev = (cnt_q == '1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= '0;
      req_q  <= 1'b0;
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      req_q  <= req_d;
      s1_q   <= s1_d;
      s2_q   <= s2_d;
    end
  end

  assign cnt = cnt_q;

  // R4: a tick at the compare value returns the counter to zero
  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !load && cnt_q == cmp) |=> (cnt_q == '0));

  // R12: the counter only moves on a tick
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  // R9: an outstanding write stays outstanding between ticks
  a_r9_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !tick) |=> pending);

endmodule

// File: rtl/mt_regs.sv
module mt_regs #(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_cmp,
  input  logic              wr_str,
  input  logic [31:0]       wdata,
  input  logic              match_ev,
  input  logic              wrap_ev,
  output logic [SEL_W-1:0]  clksel,
  output logic              ie,
  output logic              match_flg,
  output logic              wrap_flg,
  output logic [CNT_W-1:0]  cmp,
  output logic [NUM_CH-1:0] str
);

  localparam int  MATCH_BIT = (CNT_W == 16) ? 7 : 15;
  localparam int  WRAP_BIT  = 14;
  localparam int  IE_BIT    = 6;
  localparam bit  HAS_WRAP  = (CNT_W != 16);

  logic [SEL_W-1:0]  sel_q, sel_d;
  logic              ie_q, ie_d;
  logic              mf_q, mf_d;
  logic [CNT_W-1:0]  cmp_q, cmp_d;
  logic [NUM_CH-1:0] str_q, str_d;
  logic              unused_wd;

  assign unused_wd = ^wdata;

  always_comb begin
    sel_d = wr_ctrl ? wdata[SEL_W-1:0] : sel_q;
    ie_d  = wr_ctrl ? wdata[IE_BIT]    : ie_q;
    cmp_d = wr_cmp  ? wdata[CNT_W-1:0] : cmp_q;
    str_d = wr_str  ? wdata[NUM_CH-1:0] : str_q;
    // a match outranks a clearing write in the same cycle
    if (match_ev)     mf_d = 1'b1;
    else if (wr_ctrl) mf_d = mf_q & wdata[MATCH_BIT];
    else              mf_d = mf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      ie_q  <= 1'b0;
      mf_q  <= 1'b0;
      cmp_q <= '0;
      str_q <= '0;
    end else begin
      sel_q <= sel_d;
      ie_q  <= ie_d;
      mf_q  <= mf_d;
      cmp_q <= cmp_d;
      str_q <= str_d;
    end
  end

  generate
    if (HAS_WRAP) begin : g_wrap
      logic wf_q, wf_d;
      always_comb begin
        if (wrap_ev)      wf_d = 1'b1;
        else if (wr_ctrl) wf_d = wf_q & wdata[WRAP_BIT];
        else              wf_d = wf_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wf_q <= 1'b0;
        else        wf_q <= wf_d;
      end
      assign wrap_flg = wf_q;

      // R11: a wrap event always leaves the wrap flag set
      a_r11_wrap_set: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_ev |=> wrap_flg);
    end else begin : g_nowrap
      logic unused_wrap;
      assign unused_wrap = wrap_ev;
      assign wrap_flg    = 1'b0;
    end
  endgenerate

  assign clksel    = sel_q;
  assign ie        = ie_q;
  assign match_flg = mf_q;
  assign cmp       = cmp_q;
  assign str       = str_q;

  // R6: a match is never lost to a concurrent clear
  a_r6_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> match_flg);

  // R5: the flag only drops after a control write
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flg && !wr_ctrl) |=> match_flg);

  // R8: writing zero with no match present clears the flag and the enable
  a_r8_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata == 32'd0 && !match_ev) |=> (!match_flg && !ie));

endmodule

// File: rtl/match_timer.sv
module match_timer #(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 4,
  parameter int CH_IDX = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_str,
  input  logic [3:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  import mt_pkg::*;

  localparam int SEL_W     = 2;
  localparam int BYTE_SH   = (CNT_W == 16) ? 1 : 2;
  localparam int MATCH_BIT = (CNT_W == 16) ? 7 : 15;
  localparam int WRAP_BIT  = 14;
  localparam int IE_BIT    = 6;
  localparam bit HAS_WRAP  = (CNT_W != 16);

  logic [1:0]        rst_sync_q;
  logic              rst_int;
  word_e             word;
  logic              wr_ctrl, wr_cnt, wr_cmp, wr_str;
  logic              tick, run;
  logic [SEL_W-1:0]  clksel;
  logic              ie, match_flg, wrap_flg, match_ev, wrap_ev;
  logic [CNT_W-1:0]  cmp, cnt;
  logic [NUM_CH-1:0] str;
  logic [31:0]       ctrl_rd;
  logic              unused_addr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int = rst_sync_q[1];

  assign unused_addr = ^addr;

  always_comb begin
    word    = word_e'(addr[BYTE_SH +: 2]);
    wr_ctrl = wr_en && !sel_str && (word == WRD_CTRL);
    wr_cnt  = wr_en && !sel_str && (word == WRD_CNT);
    wr_cmp  = wr_en && !sel_str && (word == WRD_CMP);
    wr_str  = wr_en && sel_str;
  end

  mt_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_int),
    .sel   (clksel),
    .tick  (tick)
  );

  mt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_int),
    .tick     (tick),
    .run      (run),
    .cmp      (cmp),
    .wr_cnt   (wr_cnt),
    .wval     (wdata[CNT_W-1:0]),
    .cnt      (cnt),
    .match_ev (match_ev),
    .wrap_ev  (wrap_ev)
  );

  mt_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int),
    .wr_ctrl   (wr_ctrl),
    .wr_cmp    (wr_cmp),
    .wr_str    (wr_str),
    .wdata     (wdata),
    .match_ev  (match_ev),
    .wrap_ev   (wrap_ev),
    .clksel    (clksel),
    .ie        (ie),
    .match_flg (match_flg),
    .wrap_flg  (wrap_flg),
    .cmp       (cmp),
    .str       (str)
  );

  assign run = str[CH_IDX];
  assign irq = match_flg & ie;

  always_comb begin
    ctrl_rd              = '0;
    ctrl_rd[SEL_W-1:0]   = clksel;
    ctrl_rd[IE_BIT]      = ie;
    ctrl_rd[MATCH_BIT]   = match_flg;
    if (HAS_WRAP) ctrl_rd[WRAP_BIT] = wrap_flg;
  end

  always_comb begin
    if (sel_str) begin
      rdata = 32'(str);
    end else begin
      unique case (word)
        WRD_CTRL: rdata = ctrl_rd;
        WRD_CNT:  rdata = 32'(cnt);
        WRD_CMP:  rdata = 32'(cmp);
        default:  rdata = '0;
      endcase
    end
  end

  // R7: the interrupt level holds until software writes
  a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_int)
    (irq && !wr_en) |=> irq);

  // R2: a run-register write with this channel's bit clear stops the count
  a_r2_stop: assert property (@(posedge clk) disable iff (!rst_int)
    (wr_str && !wdata[CH_IDX] && !tick) |=> !run);

endmodule

// File: tb/tb_match_timer.sv
module tb_match_timer;

  logic        clk;
  logic        rst_n;
  logic        sel_str;
  logic [3:0]  addr;
  logic        wr_en;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int n_chk;
  int n_fail;
  int cyc;
  bit done;

  match_timer dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_str (sel_str),
    .addr    (addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq     (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // {clock select, compare value}
  localparam logic [33:0] VEC [5] = '{
    {2'd0, 32'd3},
    {2'd1, 32'd2},
    {2'd0, 32'd0},
    {2'd2, 32'd1},
    {2'd0, 32'd9}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit s, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sel_str = s;
    addr    = a;
    wdata   = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic rd(input bit s, input logic [3:0] a, output logic [31:0] d);
    sel_str = s;
    addr    = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_flag(output int t, output bit ok);
    logic [31:0] d;
    ok = 1'b0;
    t  = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      rd(1'b0, 4'h0, d);
      if (d[15]) begin
        t  = cyc;
        ok = 1'b1;
        return;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int t1, t2, per, div;
    bit ok1, ok2;
    n_chk = 0; n_fail = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0; sel_str = 1'b0; addr = '0; wr_en = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(1'b0, 4'h0, d); chk("R1 control", d, 32'h0);
    rd(1'b0, 4'h4, d); chk("R1 counter", d, 32'h0);
    rd(1'b0, 4'h8, d); chk("R1 compare", d, 32'h0);
    rd(1'b1, 4'h0, d); chk("R1 run register", d, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R10 address map
    wr(1'b0, 4'h8, 32'h1234_5678);
    rd(1'b0, 4'h8, d); chk("R10 compare at 0x8", d, 32'h1234_5678);
    rd(1'b0, 4'hC, d); chk("R10 offset 0xC", d, 32'h0);
    rd(1'b0, 4'h0, d); chk("R10 control untouched", d, 32'h0);

    // R9 delayed counter write, R12 stopped counter holds
    wr(1'b0, 4'h4, 32'd7);
    rd(1'b0, 4'h4, d); chk("R9 read while pending", d, 32'h0);
    repeat (20) @(negedge clk);
    rd(1'b0, 4'h4, d); chk("R9 value after two ticks", d, 32'd7);
    wr(1'b1, 4'h0, 32'hE);
    rd(1'b1, 4'h0, d); chk("R2 run register readback", d, 32'hE);
    repeat (40) @(negedge clk);
    rd(1'b0, 4'h4, d); chk("R12 counter holds when stopped", d, 32'd7);
    wr(1'b1, 4'h0, 32'hF);
    repeat (40) @(negedge clk);
    rd(1'b0, 4'h4, d); chk("R2 own bit starts count", {31'd0, (d > 32'd7)}, 32'd1);
    wr(1'b1, 4'h0, 32'hE);
    rd(1'b1, 4'h0, d); chk("R2 other bits preserved", d, 32'hE);

    // R3 / R4 period table
    for (int v = 0; v < 5; v++) begin
      div = 1 << (3 + 2 * int'(VEC[v][33:32]));
      per = (int'(VEC[v][31:0]) + 1) * div;
      wr(1'b1, 4'h0, 32'hE);
      wr(1'b0, 4'h0, {30'd0, VEC[v][33:32]});
      wr(1'b0, 4'h8, VEC[v][31:0]);
      wr(1'b0, 4'h4, 32'd0);
      repeat (2 * div + 4) @(negedge clk);
      rd(1'b0, 4'h0, d); chk("R3 clock select readback", {30'd0, d[1:0]}, {30'd0, VEC[v][33:32]});
      wr(1'b1, 4'h0, 32'hF);
      wait_flag(t1, ok1);
      rd(1'b0, 4'h4, d); chk("R4 counter zero after match", d, 32'h0);
      wr(1'b0, 4'h0, {30'd0, VEC[v][33:32]});
      wait_flag(t2, ok2);
      chk("R4 match period", (ok1 && ok2) ? 32'(t2 - t1) : 32'hFFFF_FFFF, 32'(per));
    end

    // R6 match and clear in the same cycle
    wr(1'b1, 4'h0, 32'hE);
    wr(1'b0, 4'h0, 32'h0);
    wr(1'b0, 4'h8, 32'd3);
    wr(1'b0, 4'h4, 32'd0);
    repeat (20) @(negedge clk);
    wr(1'b1, 4'h0, 32'hF);
    wait_flag(t1, ok1);
    repeat (31) @(negedge clk);
    sel_str = 1'b0; addr = 4'h0; wdata = 32'h0; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd(1'b0, 4'h0, d); chk("R6 match wins over clear", {31'd0, d[15]}, 32'd1);
    rd(1'b0, 4'h4, d); chk("R6 collision was at a match", d, 32'h0);
    wr(1'b1, 4'h0, 32'hE);

    // R5 / R7 / R8 with the counter stopped and the flag set
    wr(1'b0, 4'h0, 32'h0000_8040);
    rd(1'b0, 4'h0, d); chk("R5 writing one keeps flag", {31'd0, d[15]}, 32'd1);
    chk("R7 irq with flag and enable", {31'd0, irq}, 32'd1);
    repeat (5) @(negedge clk);
    chk("R7 irq is a held level", {31'd0, irq}, 32'd1);
    wr(1'b0, 4'h0, 32'h0);
    rd(1'b0, 4'h0, d); chk("R8 zero write clears control", d, 32'h0);
    chk("R8 irq low after zero write", {31'd0, irq}, 32'd0);
    wr(1'b1, 4'h0, 32'hF);
    wait_flag(t1, ok1);
    chk("R8 flag set again", {31'd0, ok1}, 32'd1);
    chk("R7 irq low with enable clear", {31'd0, irq}, 32'd0);
    wr(1'b1, 4'h0, 32'hE);

    // R11 wrap flag
    wr(1'b0, 4'h0, 32'h0);
    wr(1'b0, 4'h8, 32'd5);
    wr(1'b0, 4'h4, 32'hFFFF_FFFE);
    repeat (20) @(negedge clk);
    wr(1'b1, 4'h0, 32'hF);
    repeat (30) @(negedge clk);
    rd(1'b0, 4'h0, d); chk("R11 wrap flag without match", d & 32'hC000, 32'h4000);
    wr(1'b1, 4'h0, 32'hE);
    wr(1'b0, 4'h0, 32'h0000_8000);
    rd(1'b0, 4'h0, d); chk("R11 wrap flag cleared by zero", d & 32'hC000, 32'h0);

    finish_run();
  end

endmodule